// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits behind a simple 32-bit register bus and drives a small behavioural fuse array. Software writes a command code, a row address and write data, then writes 1 to the start register. The block stays busy for a configurable number of cycles, carries out the command and reports completion in a status register. Software clears start afterwards, which also clears the completion flag.

The commands are row read, row program, program unlock and program relock. Programming is refused until four unlock commands have completed, each carrying one value of a fixed key sequence. Programming only ever sets fuse bits, so a row accumulates ones. A row is one or two 32-bit words, chosen by a parameter. With two words, a single command moves 64 bits.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, every readable register reads 0. This includes the status register, whose bit 0 is busy, bit 1 is command-done and bit 2 is program-ok.
- R2: Writing 1 to bit 0 of the start register (offset 0x08) has no effect while bit 0 of the mode register (offset 0x00) is 0. Status stays 0.
- R3: Bit 0 of the start register launches the latched command when the block is idle with command-done clear. Busy then holds for READ_LAT cycles for every command except program (code 0x08), which holds for PROG_LAT cycles. Command-done sets in the cycle busy falls, and busy and done are never set together.
- R4: Writing 0 to the start register clears command-done. Writing 1 while busy or while command-done is set is ignored.
- R5: The command register (offset 0x04) keeps only its low 6 bits. The address register (offset 0x28) keeps only its low 16 bits.
- R6: The read command (code 0x00) loads the addressed row into the read-data words: word 0 at offset 0x10 and word 1 at 0x5C. A row address at or beyond NUM_ROWS reads as zeros.
- R7: The unlock command (code 0x02), completed four times with write-data word 0 (offset 0x2C) equal to 0xF, 0x4, 0x8 and 0xD in that order, unlocks programming and sets program-ok on the fourth completion. No earlier step sets it.
- R8: An unlock command whose write data differs from the expected key value returns the sequence to its first step.
- R9: A program command issued while locked completes with command-done set and leaves the fuse array unchanged.
- R10: A program command issued while unlocked replaces the addressed row with the old row ORed with the write data. Word 1 of the write data is at offset 0x64.
- R11: The relock command (code 0x03) locks programming and sets program-ok when it completes. Launching any command clears program-ok.
- R12: Every register read returns the value implied by the writes and commands issued so far, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |

## Verification
The bench builds the block with two-word rows, an eight-row array, a read latency of 3 and a program latency of 6. Two-word rows exercise the second read and write offsets and the 64-bit OR merge. The small array makes an out-of-range row address easy to reach. The unequal latencies make the program-versus-other latency split visible in the cycle counts.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int BUS_AW = 8;
  localparam int CMD_W = 6;
  localparam int ROW_ADDR_W = 16;

  localparam logic [BUS_AW-1:0] OFF_MODE   = 8'h00;
  localparam logic [BUS_AW-1:0] OFF_CMD    = 8'h04;
  localparam logic [BUS_AW-1:0] OFF_START  = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_STATUS = 8'h0C;
  localparam logic [BUS_AW-1:0] OFF_ADDR   = 8'h28;

  localparam logic [CMD_W-1:0] CMD_READ   = 6'h00;
  localparam logic [CMD_W-1:0] CMD_UNLOCK = 6'h02;
  localparam logic [CMD_W-1:0] CMD_RELOCK = 6'h03;
  localparam logic [CMD_W-1:0] CMD_PROG   = 6'h08;

  typedef struct packed {
    logic startSet;
    logic startClr;
  } bus_evt_t;

  typedef struct packed {
    logic rowRead;
    logic rowProg;
  } row_strb_t;

  function automatic logic [BUS_AW-1:0] rdOff(input int w);
    return (w == 0) ? 8'h10 : 8'h5C;
  endfunction

  function automatic logic [BUS_AW-1:0] wrOff(input int w);
    return (w == 0) ? 8'h2C : 8'h64;
  endfunction

  function automatic logic [3:0] unlockKey(input logic [1:0] step);
    case (step)
      2'd0: return 4'hF;
      2'd1: return 4'h4;
      2'd2: return 4'h8;
      default: return 4'hD;
    endcase
  endfunction
endpackage

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int ROW_WORDS = 1,
  parameter int NUM_ROWS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  row_strb_t strb,
  input  logic busy,
  input  logic done,
  input  logic progOk,
  output bus_evt_t evt,
  output logic modeEn,
  output logic [CMD_W-1:0] cmdReg,
  output logic [31:0] keyData,
  output logic [32*ROW_WORDS-1:0] row0Bits
);
  localparam int ROW_BITS = 32 * ROW_WORDS;
  localparam int IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  logic startReg;
  logic [ROW_ADDR_W-1:0] addrReg;
  logic [ROW_BITS-1:0] wrRow, rdRow;
  logic [ROW_BITS-1:0] fuse [NUM_ROWS];
  logic inRange;
  logic [IDX_W-1:0] rowIdx;
  logic startWr;

  assign inRange = {16'b0, addrReg} < 32'(NUM_ROWS);
  assign rowIdx = addrReg[IDX_W-1:0];
  assign startWr = regWrEn && (regAddr == OFF_START);
  assign evt.startSet = startWr && regWrData[0] && modeEn;
  assign evt.startClr = startWr && !regWrData[0];
  assign keyData = wrRow[31:0];
  assign row0Bits = fuse[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn <= 1'b0;
      cmdReg <= '0;
      startReg <= 1'b0;
      addrReg <= '0;
      wrRow <= '0;
    end else if (regWrEn) begin
      if (regAddr == OFF_MODE) modeEn <= regWrData[0];
      if (regAddr == OFF_CMD) cmdReg <= regWrData[CMD_W-1:0];
      if (regAddr == OFF_START) startReg <= regWrData[0];
      if (regAddr == OFF_ADDR) addrReg <= regWrData[ROW_ADDR_W-1:0];
      for (int w = 0; w < ROW_WORDS; w++)
        if (regAddr == wrOff(w)) wrRow[32*w +: 32] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdRow <= '0;
    else if (strb.rowRead) rdRow <= inRange ? fuse[rowIdx] : '0;
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) fuse[r] <= '0;
      else if (strb.rowProg && inRange && rowIdx == IDX_W'(r))
        fuse[r] <= fuse[r] | wrRow;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_MODE:   regRdData = {31'b0, modeEn};
      OFF_CMD:    regRdData = {26'b0, cmdReg};
      OFF_START:  regRdData = {31'b0, startReg};
      OFF_STATUS: regRdData = {29'b0, progOk, done, busy};
      OFF_ADDR:   regRdData = {16'b0, addrReg};
      default: begin
        for (int w = 0; w < ROW_WORDS; w++) begin
          if (regAddr == rdOff(w)) regRdData = rdRow[32*w +: 32];
          if (regAddr == wrOff(w)) regRdData = wrRow[32*w +: 32];
        end
      end
    endcase
  end
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int READ_LAT = 4,
  parameter int PROG_LAT = 32
) (
  input  logic clk,
  input  logic rstN,
  input  bus_evt_t evt,
  input  logic [CMD_W-1:0] cmdReg,
  input  logic [31:0] keyData,
  output logic busy,
  output logic done,
  output logic progOk,
  output logic unlocked,
  output row_strb_t strb
);
  localparam int MAX_LAT = (PROG_LAT > READ_LAT) ? PROG_LAT : READ_LAT;
  localparam int CNT_W = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] actCmd;
  logic [1:0] step;
  logic launch, finish, keyHit;

  assign launch = evt.startSet && !busy && !done;
  assign finish = busy && (cnt == '0);
  assign keyHit = keyData == {28'b0, unlockKey(step)};
  assign strb.rowRead = finish && (actCmd == CMD_READ);
  assign strb.rowProg = finish && (actCmd == CMD_PROG) && unlocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      progOk <= 1'b0;
      unlocked <= 1'b0;
      step <= '0;
      cnt <= '0;
      actCmd <= '0;
    end else begin
      if (evt.startClr) done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        actCmd <= cmdReg;
        progOk <= 1'b0;
        if (cmdReg == CMD_PROG) cnt <= CNT_W'(PROG_LAT - 1);
        else cnt <= CNT_W'(READ_LAT - 1);
      end else if (busy && !finish) begin
        cnt <= cnt - 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (actCmd == CMD_UNLOCK) begin
          if (unlocked) progOk <= 1'b1;
          else if (!keyHit) step <= '0;
          else if (step == 2'd3) begin
            unlocked <= 1'b1;
            step <= '0;
            progOk <= 1'b1;
          end else step <= step + 1'b1;
        end else if (actCmd == CMD_RELOCK) begin
          unlocked <= 1'b0;
          step <= '0;
          progOk <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int ROW_WORDS = 1,
  parameter int NUM_ROWS = 16,
  parameter int READ_LAT = 4,
  parameter int PROG_LAT = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [7:0] regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);
  bus_evt_t evt;
  row_strb_t strb;
  logic busy, done, progOk, unlocked, modeEn;
  logic [CMD_W-1:0] cmdReg;
  logic [31:0] keyData;
  logic [32*ROW_WORDS-1:0] row0Bits;

  otp_datapath #(.ROW_WORDS(ROW_WORDS), .NUM_ROWS(NUM_ROWS)) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .busy(busy), .done(done), .progOk(progOk), .evt(evt),
    .modeEn(modeEn), .cmdReg(cmdReg), .keyData(keyData), .row0Bits(row0Bits)
  );

  otp_ctrl #(.READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT)) i_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .cmdReg(cmdReg), .keyData(keyData),
    .busy(busy), .done(done), .progOk(progOk), .unlocked(unlocked), .strb(strb)
  );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int ROW_BITS = 32
) (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic [7:0] regAddr,
  input logic [31:0] regWrData,
  input logic busy,
  input logic done,
  input logic progOk,
  input logic unlocked,
  input logic modeEn,
  input logic [ROW_BITS-1:0] row0Bits
);
  p_ignore_nomode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h08 && regWrData[0] && !modeEn && !busy) |=> !busy);

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_done_on_finish_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_start_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h08 && !regWrData[0] && !busy) |=> !done);

  p_ok_on_unlock_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> progOk);

  p_fuse_monotone_r10: assert property (@(posedge clk) disable iff (!rstN)
    (row0Bits & $past(row0Bits)) == $past(row0Bits));

  p_ok_on_relock_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlocked) |-> progOk);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.ROW_BITS(32 * ROW_WORDS)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .busy(busy), .done(done), .progOk(progOk),
  .unlocked(unlocked), .modeEn(modeEn), .row0Bits(row0Bits)
);

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 2;
  localparam int NR = 8;
  localparam int RL = 3;
  localparam int PL = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn;
  logic [7:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  otp_fuse_ctrl #(.ROW_WORDS(RW), .NUM_ROWS(NR), .READ_LAT(RL), .PROG_LAT(PL)) i_otp_fuse_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit mMode, mStart, mBusy, mDone, mOk, mUnl;
  int mCmd, mAct, mRemain, mStep;
  logic [15:0] mAddr;
  logic [31:0] mW0, mW1, mR0, mR1;
  logic [63:0] mFuse [NR];
  int keys [4] = '{15, 4, 8, 13};

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mStart = 0; mBusy = 0; mDone = 0; mOk = 0; mUnl = 0;
      mCmd = 0; mAct = 0; mRemain = 0; mStep = 0;
      mAddr = 0; mW0 = 0; mW1 = 0; mR0 = 0; mR1 = 0;
      for (int i = 0; i < NR; i++) mFuse[i] = 0;
    end else begin
      if (mBusy) begin
        if (mRemain == 1) begin
          mBusy = 0; mDone = 1;
          case (mAct)
            0: if (mAddr < NR) {mR1, mR0} = mFuse[mAddr]; else {mR1, mR0} = 0;
            2: if (mUnl) mOk = 1;
               else if (mW0 == 32'(keys[mStep])) begin
                 if (mStep == 3) begin mUnl = 1; mStep = 0; mOk = 1; end
                 else mStep++;
               end else mStep = 0;
            3: begin mUnl = 0; mStep = 0; mOk = 1; end
            8: if (mUnl && mAddr < NR) mFuse[mAddr] = mFuse[mAddr] | {mW1, mW0};
            default: ;
          endcase
        end else mRemain--;
      end else if (regWrEn && regAddr == 8'h08 && regWrData[0] && mMode && !mDone) begin
        mBusy = 1; mAct = mCmd; mOk = 0;
        mRemain = (mCmd == 8) ? PL : RL;
      end
      if (regWrEn) begin
        case (regAddr)
          8'h00: mMode = regWrData[0];
          8'h04: mCmd = int'(regWrData[5:0]);
          8'h08: begin mStart = regWrData[0]; if (!regWrData[0]) mDone = 0; end
          8'h28: mAddr = regWrData[15:0];
          8'h2C: mW0 = regWrData;
          8'h64: mW1 = regWrData;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, mMode};
      8'h04: return 32'(mCmd);
      8'h08: return {31'b0, mStart};
      8'h0C: return {29'b0, mOk, mDone, mBusy};
      8'h10: return mR0;
      8'h28: return {16'b0, mAddr};
      8'h2C: return mW0;
      8'h5C: return mR1;
      8'h64: return mW1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R12: compare every cycle against the model
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !finished) chk("R12 cycle read", regRdData, expRead(regAddr));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic runCmd(input logic [5:0] c, output int cyc);
    logic [31:0] s;
    wr(8'h04, {26'b0, c});
    wr(8'h08, 1);
    rd(8'h0C, s);
    chk("R3 busy after launch", {31'b0, s[0]}, 1);
    cyc = 0;
    while (!s[1] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      rd(8'h0C, s);
    end
    wr(8'h08, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cyc;
    regWrEn = 0; regAddr = 0; regWrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    rd(8'h0C, d); chk("R1 status reset", d, 0);
    rd(8'h00, d); chk("R1 mode reset", d, 0);
    rd(8'h10, d); chk("R1 read data reset", d, 0);

    wr(8'h08, 1);
    repeat (2) @(negedge clk);
    rd(8'h0C, d); chk("R2 start ignored without mode", d, 0);
    wr(8'h08, 0);
    wr(8'h00, 1);

    wr(8'h28, 32'h0012_0005);
    rd(8'h28, d); chk("R5 address width", d, 32'h5);
    wr(8'h04, 32'hFF);
    rd(8'h04, d); chk("R5 command width", d, 32'h3F);

    wr(8'h28, 1);
    runCmd(6'h00, cyc);
    chk("R3 read latency", 32'(cyc), RL);
    rd(8'h10, d); chk("R6 blank row word0", d, 0);
    rd(8'h5C, d); chk("R6 blank row word1", d, 0);

    wr(8'h04, 0);
    wr(8'h08, 1);
    repeat (RL) @(negedge clk);
    rd(8'h0C, d); chk("R3 done after read", d, 32'h2);
    wr(8'h08, 1);
    @(negedge clk);
    rd(8'h0C, d); chk("R4 start ignored while done", d, 32'h2);
    wr(8'h08, 0);
    rd(8'h0C, d); chk("R4 start clear drops done", d, 0);

    wr(8'h28, 2); wr(8'h2C, 32'hA5); wr(8'h64, 32'h77);
    runCmd(6'h08, cyc);
    chk("R3 program latency", 32'(cyc), PL);
    runCmd(6'h00, cyc);
    rd(8'h10, d); chk("R9 locked program word0", d, 0);
    rd(8'h5C, d); chk("R9 locked program word1", d, 0);

    foreach (keys[i]) begin
      wr(8'h2C, (i == 2) ? 32'h7 : 32'(keys[i]));
      runCmd(6'h02, cyc);
    end
    rd(8'h0C, d); chk("R8 wrong key no unlock", d, 0);
    for (int i = 0; i < 4; i++) begin
      wr(8'h2C, 32'(keys[i]));
      runCmd(6'h02, cyc);
      rd(8'h0C, d);
      chk("R7 unlock progress", d, (i == 3) ? 32'h4 : 32'h0);
    end

    wr(8'h28, 2); wr(8'h2C, 32'hF0); wr(8'h64, 32'h1234_0000);
    runCmd(6'h08, cyc);
    runCmd(6'h00, cyc);
    rd(8'h10, d); chk("R10 program word0", d, 32'hF0);
    rd(8'h5C, d); chk("R10 program word1", d, 32'h1234_0000);
    wr(8'h2C, 32'h0F00_000F); wr(8'h64, 32'h1);
    runCmd(6'h08, cyc);
    runCmd(6'h00, cyc);
    rd(8'h10, d); chk("R10 OR merge word0", d, 32'h0F00_00FF);
    rd(8'h5C, d); chk("R10 OR merge word1", d, 32'h1234_0001);

    wr(8'h28, 9);
    runCmd(6'h00, cyc);
    rd(8'h10, d); chk("R6 out of range row", d, 0);

    runCmd(6'h03, cyc);
    rd(8'h0C, d); chk("R11 relock sets ok", d, 32'h4);
    wr(8'h04, 0);
    wr(8'h08, 1);
    rd(8'h0C, d); chk("R11 launch clears ok", d, 32'h1);
    repeat (RL) @(negedge clk);
    wr(8'h08, 0);
    wr(8'h28, 3); wr(8'h2C, 32'hFFFF_FFFF);
    runCmd(6'h08, cyc);
    runCmd(6'h00, cyc);
    rd(8'h10, d); chk("R11 relocked program blocked", d, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule